// File: doc/BRIEF.md
# Four-Channel Buffered Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs. Software reaches it through a one-cycle register port that has a select, a write strobe, a byte address and a 32-bit data word. Every channel has its own clock prescaler, polarity and period counter. The counter runs from zero up to the programmed period value and then wraps. The output of a channel is at its inactive level at the start of each period. It changes to the active level when the counter reaches the duty value.

Global registers start and stop channels and report which ones are running. A sticky flag register records each period wrap and clears when it is read. The duty and period of a running channel change only through staging registers. A staged value is copied into the live setting at the next wrap, so no period is ever cut short or stretched by a write. Direct writes to the live settings and to the mode register take effect only while the channel is stopped.

Top module: `pwm_bank`

## Requirements
- R1: After reset all outputs are 0, every channel is stopped, and every register reads 0.
- R2: A write to 0x04 starts each channel whose bit in data[3:0] is 1. A write to 0x08 stops each such channel. Zero bits leave their channel unchanged. A read of 0x0C returns the running channels in bits [3:0]. A read of 0x04 or 0x08 returns 0.
- R3: For channel c the window base is 0x200 + 0x20*c. The live period P is at +0x0C and the live duty D is at +0x04. One period lasts P+1 counter ticks, with the counter going 0..P. When D is 0 the output is inactive for the whole period. When D is at least P the output is active for the whole period. Otherwise the output is inactive while the counter is below D and active from D to P.
- R4: Bit 9 of the mode register (+0x00) sets polarity. With the bit at 0 the active level is 1 and the inactive level is 0. With the bit at 1 the levels are swapped. A stopped channel drives its inactive level.
- R5: Bits [3:0] of the mode register hold a prescale value k. The counter advances once every 2^k clock cycles.
- R6: A write to the duty stage (+0x08) or the period stage (+0x10) is not applied at once. The value is copied into the live register at the next wrap from P to 0. The stage registers read back their last written values.
- R7: When bit 10 of the mode register is 1, a write to +0x08 goes to the period stage instead of the duty stage.
- R8: At each wrap the channel's bit in the flag register (0x1C, bits [3:0]) is set. A read of 0x1C returns the flags and clears them. A wrap in the same cycle as that read still leaves its bit set.
- R9: A stopped channel keeps its counter at 0 and raises no flags. Writes to the mode, live duty and live period registers are ignored while the channel runs. A direct write to live duty or live period, made while the channel is stopped, cancels any staged value for that field.
- R10: Reads of all mapped registers return the stored values. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
A wrong counter, prescale phase or live setting shows up on the output pins within one period. The bench compares the pins against an independent model on every cycle, so such a fault is reported in the first cycle where an edge lands in the wrong place. A lost or stale staged value shows up at the next wrap, either as an edge at the wrong point or as a wrong value when the live register is read back. A flag that is missed, or that lingers after a read, shows up on the very next read of the flag register.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int NUM_CH_DEF   = 4;
    localparam int ADDR_W_DEF   = 10;
    localparam int DATA_W_DEF   = 32;
    localparam int CNT_W_DEF    = 16;
    localparam int PRE_W_DEF    = 4;

    // global register offsets
    localparam int OFS_START    = 'h004;
    localparam int OFS_STOP     = 'h008;
    localparam int OFS_RUNNING  = 'h00C;
    localparam int OFS_FLAGS    = 'h01C;

    // channel windows
    localparam int WIN_BASE     = 'h200;
    localparam int WIN_STRIDE_LG = 5;

    // offsets within a channel window
    localparam int WOFS_MODE    = 'h00;
    localparam int WOFS_DUTY    = 'h04;
    localparam int WOFS_DSTAGE  = 'h08;
    localparam int WOFS_PRD     = 'h0C;
    localparam int WOFS_PSTAGE  = 'h10;

    // mode register bit positions
    localparam int MODE_POL_BIT = 9;
    localparam int MODE_SEL_BIT = 10;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] shift,
    output logic             tick
);
    localparam int DIV_W = (1 << PRE_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        st_d = st_q;
        mask = (DIV_W'(1) << shift) - DIV_W'(1);
        tick = run && ((st_q.div & mask) == mask);
        if (run) begin
            st_d.div = st_q.div + DIV_W'(1);
        end else begin
            st_d.div = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_mode,
    input  logic              wr_duty,
    input  logic              wr_dstage,
    input  logic              wr_prd,
    input  logic              wr_pstage,
    input  logic [DATA_W-1:0] wdata,
    output logic [PRE_W-1:0]  shift_o,
    output logic              pol_o,
    output logic              sel_o,
    output logic [CNT_W-1:0]  duty_o,
    output logic [CNT_W-1:0]  dstage_o,
    output logic [CNT_W-1:0]  prd_o,
    output logic [CNT_W-1:0]  pstage_o,
    output logic              wrap_o,
    output logic              pwm_o
);
    typedef struct packed {
        logic [PRE_W-1:0] shift;
        logic             pol;
        logic             sel;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] prd;
        logic [CNT_W-1:0] dstage;
        logic [CNT_W-1:0] pstage;
        logic             dpend;
        logic             ppend;
        logic [CNT_W-1:0] cnt;
        logic             out;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     tick;
    logic     wrap;
    logic     act;

    pwm_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .shift (st_q.shift),
        .tick  (tick)
    );

    always_comb begin
        st_d = st_q;
        wrap = tick && (st_q.cnt == st_q.prd);

        // counter
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + CNT_W'(1);
        end

        // staged values land at the wrap
        if (wrap) begin
            if (st_q.dpend) st_d.duty = st_q.dstage;
            if (st_q.ppend) st_d.prd  = st_q.pstage;
            st_d.dpend = 1'b0;
            st_d.ppend = 1'b0;
        end

        // live settings change only while stopped
        if (!run) begin
            if (wr_mode) begin
                st_d.shift = wdata[PRE_W-1:0];
                st_d.pol   = wdata[MODE_POL_BIT];
                st_d.sel   = wdata[MODE_SEL_BIT];
            end
            if (wr_duty) begin
                st_d.duty  = wdata[CNT_W-1:0];
                st_d.dpend = 1'b0;
            end
            if (wr_prd) begin
                st_d.prd   = wdata[CNT_W-1:0];
                st_d.ppend = 1'b0;
            end
        end

        // staging writes are taken at any time
        if (wr_dstage) begin
            if (st_q.sel) begin
                st_d.pstage = wdata[CNT_W-1:0];
                st_d.ppend  = 1'b1;
            end else begin
                st_d.dstage = wdata[CNT_W-1:0];
                st_d.dpend  = 1'b1;
            end
        end
        if (wr_pstage) begin
            st_d.pstage = wdata[CNT_W-1:0];
            st_d.ppend  = 1'b1;
        end

        // output level follows the next state
        act = (st_d.duty != '0) &&
              ((st_d.duty >= st_d.prd) || (st_d.cnt >= st_d.duty));
        st_d.out = (run && act) ^ st_d.pol;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_o  = st_q.shift;
    assign pol_o    = st_q.pol;
    assign sel_o    = st_q.sel;
    assign duty_o   = st_q.duty;
    assign dstage_o = st_q.dstage;
    assign prd_o    = st_q.prd;
    assign pstage_o = st_q.pstage;
    assign wrap_o   = wrap;
    assign pwm_o    = st_q.out;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int PRE_W  = PRE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int WIN_LSB = WIN_STRIDE_LG + CH_W;

    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] flags;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic                     win_hit;
    logic [CH_W-1:0]          win_ch;
    logic [WIN_STRIDE_LG-1:0] win_ofs;
    logic                     do_wr;
    logic                     do_rd;
    logic                     flag_rd;

    logic [NUM_CH-1:0] en_vec;
    logic [NUM_CH-1:0] flag_vec;
    logic [NUM_CH-1:0] wrap_vec;

    logic [PRE_W-1:0] shift_a  [NUM_CH];
    logic             pol_a    [NUM_CH];
    logic             sel_a    [NUM_CH];
    logic [CNT_W-1:0] duty_a   [NUM_CH];
    logic [CNT_W-1:0] dstage_a [NUM_CH];
    logic [CNT_W-1:0] prd_a    [NUM_CH];
    logic [CNT_W-1:0] pstage_a [NUM_CH];

    assign do_wr   = bus_sel && bus_wr;
    assign do_rd   = bus_sel && !bus_wr;
    assign win_hit = (bus_addr >> WIN_LSB) == ADDR_W'(WIN_BASE >> WIN_LSB);
    assign win_ch  = bus_addr[WIN_STRIDE_LG +: CH_W];
    assign win_ofs = bus_addr[WIN_STRIDE_LG-1:0];
    assign flag_rd = do_rd && (bus_addr == ADDR_W'(OFS_FLAGS));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = do_wr && win_hit && (win_ch == CH_W'(i));

        pwm_chan #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (st_q.en[i]),
            .wr_mode   (hit && (win_ofs == WIN_STRIDE_LG'(WOFS_MODE))),
            .wr_duty   (hit && (win_ofs == WIN_STRIDE_LG'(WOFS_DUTY))),
            .wr_dstage (hit && (win_ofs == WIN_STRIDE_LG'(WOFS_DSTAGE))),
            .wr_prd    (hit && (win_ofs == WIN_STRIDE_LG'(WOFS_PRD))),
            .wr_pstage (hit && (win_ofs == WIN_STRIDE_LG'(WOFS_PSTAGE))),
            .wdata     (bus_wdata),
            .shift_o   (shift_a[i]),
            .pol_o     (pol_a[i]),
            .sel_o     (sel_a[i]),
            .duty_o    (duty_a[i]),
            .dstage_o  (dstage_a[i]),
            .prd_o     (prd_a[i]),
            .pstage_o  (pstage_a[i]),
            .wrap_o    (wrap_vec[i]),
            .pwm_o     (pwm_out[i])
        );
    end

    // global state: run mask and sticky wrap flags
    always_comb begin
        st_d = st_q;
        if (do_wr && (bus_addr == ADDR_W'(OFS_START))) begin
            st_d.en = st_q.en | bus_wdata[NUM_CH-1:0];
        end
        if (do_wr && (bus_addr == ADDR_W'(OFS_STOP))) begin
            st_d.en = st_q.en & ~bus_wdata[NUM_CH-1:0];
        end
        st_d.flags = (flag_rd ? '0 : st_q.flags) | wrap_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (win_hit) begin
            unique case (win_ofs)
                WIN_STRIDE_LG'(WOFS_MODE): begin
                    bus_rdata[PRE_W-1:0]    = shift_a[win_ch];
                    bus_rdata[MODE_POL_BIT] = pol_a[win_ch];
                    bus_rdata[MODE_SEL_BIT] = sel_a[win_ch];
                end
                WIN_STRIDE_LG'(WOFS_DUTY):   bus_rdata[CNT_W-1:0] = duty_a[win_ch];
                WIN_STRIDE_LG'(WOFS_DSTAGE): bus_rdata[CNT_W-1:0] = dstage_a[win_ch];
                WIN_STRIDE_LG'(WOFS_PRD):    bus_rdata[CNT_W-1:0] = prd_a[win_ch];
                WIN_STRIDE_LG'(WOFS_PSTAGE): bus_rdata[CNT_W-1:0] = pstage_a[win_ch];
                default: ;
            endcase
        end else if (bus_addr == ADDR_W'(OFS_RUNNING)) begin
            bus_rdata[NUM_CH-1:0] = st_q.en;
        end else if (bus_addr == ADDR_W'(OFS_FLAGS)) begin
            bus_rdata[NUM_CH-1:0] = st_q.flags;
        end
    end

    assign en_vec   = st_q.en;
    assign flag_vec = st_q.flags;
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] en_vec,
    input logic [NUM_CH-1:0] flag_vec,
    input logic [NUM_CH-1:0] wrap_vec
);
    logic              start_wr;
    logic              stop_wr;
    logic              flags_rd;
    logic [NUM_CH-1:0] wmask;
    logic              unused_chk;

    assign start_wr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_START));
    assign stop_wr    = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_STOP));
    assign flags_rd   = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_FLAGS));
    assign wmask      = bus_wdata[NUM_CH-1:0];
    assign unused_chk = ^bus_wdata[DATA_W-1:NUM_CH];

    AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> ((en_vec & $past(wmask)) == $past(wmask))); // R2
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> ((en_vec & $past(wmask)) == '0)); // R2
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_wr || stop_wr) |=> (en_vec == $past(en_vec))); // R2
    AST_NO_WRAP_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ((wrap_vec & ~en_vec) == '0)); // R9
    AST_FLAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_vec != '0) |=> ((flag_vec & $past(wrap_vec)) == $past(wrap_vec))); // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flags_rd |=> ((flag_vec & ~$past(wrap_vec)) == '0)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_rd |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec))); // R8
    AST_RDATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(bus_rdata)); // R10
endmodule

bind pwm_bank pwm_bank_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .en_vec    (en_vec),
    .flag_vec  (flag_vec),
    .wrap_vec  (wrap_vec)
);

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire  [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #2.5 clk = ~clk;

    pwm_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // reference model built from the requirements
    bit          m_en    [4];
    int unsigned m_pre   [4];
    logic [15:0] m_cnt   [4];
    logic [15:0] m_duty  [4];
    logic [15:0] m_prd   [4];
    logic [15:0] m_dsh   [4];
    logic [15:0] m_psh   [4];
    bit          m_dp    [4];
    bit          m_pp    [4];
    logic [3:0]  m_shift [4];
    bit          m_pol   [4];
    bit          m_sel   [4];
    bit          m_flag  [4];
    bit          m_out   [4];

    function automatic bit level_on(logic [15:0] c, logic [15:0] d, logic [15:0] p);
        return (d != 0) && ((d >= p) || (c >= d));
    endfunction

    function automatic logic [31:0] model_rd(logic [9:0] a);
        logic [31:0] v;
        int c;
        v = '0;
        c = int'(a[6:5]);
        if (a[9:7] == 3'b100) begin
            case (a[4:0])
                5'h00: begin v[3:0] = m_shift[c]; v[9] = m_pol[c]; v[10] = m_sel[c]; end
                5'h04: v[15:0] = m_duty[c];
                5'h08: v[15:0] = m_dsh[c];
                5'h0C: v[15:0] = m_prd[c];
                5'h10: v[15:0] = m_psh[c];
                default: ;
            endcase
        end else if (a == 10'h00C) begin
            for (int k = 0; k < 4; k++) v[k] = m_en[k];
        end else if (a == 10'h01C) begin
            for (int k = 0; k < 4; k++) v[k] = m_flag[k];
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_en[c] = 0; m_pre[c] = 0; m_cnt[c] = 0; m_duty[c] = 0; m_prd[c] = 0;
                m_dsh[c] = 0; m_psh[c] = 0; m_dp[c] = 0; m_pp[c] = 0; m_shift[c] = 0;
                m_pol[c] = 0; m_sel[c] = 0; m_flag[c] = 0; m_out[c] = 0;
            end
        end else begin
            for (int c = 0; c < 4; c++) begin
                automatic bit wr = bus_sel && bus_wr;
                automatic bit hit = wr && (bus_addr[9:7] == 3'b100) && (int'(bus_addr[6:5]) == c);
                automatic logic [4:0] ofs = bus_addr[4:0];
                automatic bit flag_clr = bus_sel && !bus_wr && (bus_addr == 10'h01C);
                automatic int unsigned mask = (32'd1 << m_shift[c]) - 1;
                automatic bit tick = m_en[c] && ((m_pre[c] & mask) == mask);
                automatic bit wrap = tick && (m_cnt[c] == m_prd[c]);
                automatic logic [15:0] cnt_n = m_cnt[c];
                automatic logic [15:0] duty_n = m_duty[c];
                automatic logic [15:0] prd_n = m_prd[c];
                automatic logic [15:0] dsh_n = m_dsh[c];
                automatic logic [15:0] psh_n = m_psh[c];
                automatic bit dp_n = m_dp[c];
                automatic bit pp_n = m_pp[c];
                automatic logic [3:0] shift_n = m_shift[c];
                automatic bit pol_n = m_pol[c];
                automatic bit sel_n = m_sel[c];
                automatic bit en_n = m_en[c];
                if (!m_en[c]) cnt_n = 0;
                else if (tick) cnt_n = wrap ? 16'd0 : m_cnt[c] + 16'd1;
                if (wrap) begin
                    if (m_dp[c]) duty_n = m_dsh[c];
                    if (m_pp[c]) prd_n = m_psh[c];
                    dp_n = 0; pp_n = 0;
                end
                if (hit && !m_en[c]) begin
                    if (ofs == 5'h00) begin
                        shift_n = bus_wdata[3:0]; pol_n = bus_wdata[9]; sel_n = bus_wdata[10];
                    end
                    if (ofs == 5'h04) begin duty_n = bus_wdata[15:0]; dp_n = 0; end
                    if (ofs == 5'h0C) begin prd_n = bus_wdata[15:0]; pp_n = 0; end
                end
                if (hit && ofs == 5'h08) begin
                    if (m_sel[c]) begin psh_n = bus_wdata[15:0]; pp_n = 1; end
                    else begin dsh_n = bus_wdata[15:0]; dp_n = 1; end
                end
                if (hit && ofs == 5'h10) begin psh_n = bus_wdata[15:0]; pp_n = 1; end
                if (wr && bus_addr == 10'h004 && bus_wdata[c]) en_n = 1;
                if (wr && bus_addr == 10'h008 && bus_wdata[c]) en_n = 0;
                m_out[c]   = (m_en[c] && level_on(cnt_n, duty_n, prd_n)) ^ pol_n;
                m_flag[c]  = (flag_clr ? 1'b0 : m_flag[c]) | wrap;
                m_pre[c]   = m_en[c] ? ((m_pre[c] + 1) & 32'h7FFF) : 0;
                m_cnt[c]   = cnt_n;  m_duty[c] = duty_n; m_prd[c] = prd_n;
                m_dsh[c]   = dsh_n;  m_psh[c]  = psh_n;  m_dp[c]  = dp_n; m_pp[c] = pp_n;
                m_shift[c] = shift_n; m_pol[c] = pol_n; m_sel[c] = sel_n; m_en[c] = en_n;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // outputs compared with the model on every falling edge
    always @(negedge clk) begin
        if (live) begin
            for (int c = 0; c < 4; c++) begin
                check(pwm_out[c] === m_out[c], "R3 output level vs model",
                      32'(pwm_out[c]), 32'(m_out[c]));
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [9:0] a, input string req, output logic [31:0] v);
        logic [31:0] e;
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        v = bus_rdata;
        e = model_rd(a);
        check(v === e, req, v, e);
        @(posedge clk);
        #1 bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int ch, input int n, output int k);
        k = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out[ch]) k++;
        end
    endtask

    task automatic wait_rise(input int ch);
        bit prev;
        prev = pwm_out[ch];
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int k;
        void'($urandom(32'd1789));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        live = 1;
        @(negedge clk);

        // R1 reset state
        check(pwm_out === 4'b0, "R1 outputs after reset", 32'(pwm_out), 0);
        rd(10'h00C, "R1 running after reset", v);  check(v == 0, "R1 running", v, 0);
        rd(10'h01C, "R1 flags after reset", v);    check(v == 0, "R1 flags", v, 0);
        rd(10'h20C, "R1 period after reset", v);   check(v == 0, "R1 period", v, 0);

        // R3 ch0: P=9 D=3 no prescale -> 7 active of 10
        wr(10'h200, 32'h0);
        wr(10'h20C, 32'd9);
        wr(10'h204, 32'd3);
        wr(10'h004, 32'h1);
        rd(10'h00C, "R2 running shows ch0", v);    check(v == 1, "R2 running", v, 1);
        idle(15);
        count_high(0, 10, k);                      check(k == 7, "R3 duty 3 of period 9", k, 7);

        // R9 live writes ignored while running
        wr(10'h204, 32'd5);
        rd(10'h204, "R9 duty kept while running", v);   check(v == 3, "R9 duty", v, 3);
        wr(10'h200, 32'h200);
        rd(10'h200, "R9 mode kept while running", v);   check(v == 0, "R9 mode", v, 0);

        // R5, R6 ch1 with prescale 3
        wr(10'h220, 32'd3);
        wr(10'h22C, 32'd9);
        wr(10'h224, 32'd3);
        wr(10'h004, 32'h2);
        wait_rise(1);
        wr(10'h228, 32'd6);
        rd(10'h224, "R6 duty not applied before wrap", v); check(v == 3, "R6 duty early", v, 3);
        rd(10'h228, "R6 staged duty readback", v);         check(v == 6, "R6 stage", v, 6);
        idle(100);
        rd(10'h224, "R6 duty applied at wrap", v);         check(v == 6, "R6 duty late", v, 6);
        count_high(1, 80, k);                              check(k == 32, "R5 prescale 8 active", k, 32);

        // R7 redirect staging to period
        wr(10'h008, 32'h2);
        wr(10'h220, 32'h403);
        wr(10'h004, 32'h2);
        wait_rise(1);
        wr(10'h228, 32'd7);
        idle(100);
        rd(10'h22C, "R7 period taken via duty stage", v);  check(v == 7, "R7 period", v, 7);
        rd(10'h224, "R7 duty unchanged", v);               check(v == 6, "R7 duty", v, 6);
        rd(10'h230, "R10 period stage readback", v);       check(v == 7, "R10 pstage", v, 7);
        rd(10'h220, "R10 mode readback", v);               check(v == 32'h403, "R10 mode", v, 32'h403);
        rd(10'h004, "R2 start reads zero", v);             check(v == 0, "R2 start read", v, 0);
        rd(10'h3F0, "R10 unmapped reads zero", v);         check(v == 0, "R10 unmapped", v, 0);

        // R8 flags
        rd(10'h01C, "R8 flags after running", v);   check((v & 3) == 3, "R8 flags set", v & 3, 3);
        wr(10'h008, 32'hF);
        idle(3);
        rd(10'h01C, "R8 flag read", v);
        rd(10'h01C, "R8 flags cleared by read", v); check(v == 0, "R8 cleared / R9 no flags", v, 0);
        check(pwm_out === 4'b0, "R9 stopped outputs inactive", 32'(pwm_out), 0);

        // R4 polarity on ch2
        wr(10'h240, 32'h200);
        idle(2);
        check(pwm_out[2] === 1'b1, "R4 inverted idle level", 32'(pwm_out[2]), 1);
        wr(10'h24C, 32'd9);
        wr(10'h244, 32'd3);
        wr(10'h004, 32'h4);
        idle(15);
        count_high(2, 10, k);                       check(k == 3, "R4 inverted duty", k, 3);

        // R3 corner duties on ch0
        wr(10'h204, 32'd0);
        wr(10'h004, 32'h1);
        idle(12);
        count_high(0, 10, k);                       check(k == 0, "R3 duty zero", k, 0);
        wr(10'h008, 32'h1);
        wr(10'h204, 32'd12);
        wr(10'h004, 32'h1);
        idle(12);
        count_high(0, 10, k);                       check(k == 10, "R3 duty above period", k, 10);
        wr(10'h008, 32'h1);
        wr(10'h204, 32'd9);
        wr(10'h004, 32'h1);
        idle(12);
        count_high(0, 10, k);                       check(k == 10, "R3 duty equal period", k, 10);

        // constrained random traffic, checked against the model
        for (int i = 0; i < 4000; i++) begin
            automatic int unsigned r = $urandom % 100;
            automatic int unsigned c = $urandom % 4;
            automatic logic [9:0] base = 10'h200 + 10'(c * 32);
            automatic logic [9:0] pick [9] = '{10'h00C, 10'h01C, 10'h004, base, base + 10'h4,
                                               base + 10'h8, base + 10'hC, base + 10'h10, base + 10'h14};
            if (r < 8)       wr(10'h004, $urandom % 16);
            else if (r < 14) wr(10'h008, $urandom % 16);
            else if (r < 22) wr(base, ($urandom % 3) | (($urandom % 2) << 9) | (($urandom % 2) << 10));
            else if (r < 32) wr(base + 10'h4, $urandom % 20);
            else if (r < 40) wr(base + 10'hC, $urandom % 16);
            else if (r < 52) wr(base + 10'h8, $urandom % 20);
            else if (r < 60) wr(base + 10'h10, $urandom % 16);
            else if (r < 85) rd(pick[$urandom % 9], "R10 random read vs model", v);
            else             idle(1 + $urandom % 6);
        end

        idle(5);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule